// File: doc/BRIEF.md
# Burst Memory Access Sequencer

This block stands between a processor core and a DRAM-style memory array. The core issues a read or a write of one to sixteen consecutive words, giving a virtual word address and a length field. The block looks up the page number in a small fully associative translation buffer of its own. It forms the row and column strobe addresses straight from the translated physical address, and it walks each access through a fixed order of phases: address map, one row/column strobe cycle per word, write-back, and a single dead cycle. A burst streams one word per cycle.

Two requesters share the block. A data port carries reads and writes. A lower-priority instruction-fetch port carries reads only, and it is served only when no data request is waiting. If the page is not in the buffer, the access stops before any strobe, raises a miss flag with the missing page number and waits. A refill write port then loads a new translation into the buffer, and the waiting access starts again from its map phase. The page walk itself and the electrical DRAM timing are left to other logic.

Top module: `burst_mem_seq`

## Requirements
- R1: After reset the block is idle: `d_ready` and `f_ready` are 1, and `mem_cas`, `mem_we`, `rd_valid`, `done` and `miss` are 0.
- R2: Take the cycle after the accepting clock edge as cycle 1. A one-word access (`len` = 0) that hits in the buffer spends cycle 1 in address map, strobes in cycle 2 and raises `done` in cycle 3 and in no other cycle.
- R3: A hitting burst of n = `len`+1 words strobes `mem_ras`/`mem_cas` in cycles 2 to n+1, one word per cycle, and raises `done` in cycle n+2 only, for 3+(n-1) cycles in all.
- R4: The physical word address is {PPN, offset} with a 10-bit offset. `mem_row` is its upper half (the PPN) and `mem_col` is its lower half (the offset). The column rises by one on each strobe and wraps modulo 1024 inside the page, while the row stays fixed for the whole burst.
- R5: For a read, each word that `mem_rdata` presents during a strobe comes back on `rd_data` with `rd_valid` high in the next cycle, in address order. `rd_fetch` is 1 for fetch-port accesses and 0 for data-port accesses.
- R6: For a write, `mem_we` is high in exactly the strobe cycles, `mem_wdata` carries `d_wdata`, and `rd_valid` stays low.
- R7: The cycle after `done` is a dead cycle in which neither `d_ready` nor `f_ready` is high. Both ready signals return in the cycle after that.
- R8: The data port has priority. `f_ready` is high only when the block is idle and `d_valid` is low, so if both requests arrive in the same idle cycle the data request is taken and the fetch waits.
- R9: The buffer holds 16 translations. A hit replaces the 14-bit virtual page number (address bits 23:10) with the stored 10-bit physical page number.
- R10: On a miss, from cycle 2 on the block holds `miss` high with `miss_vpn` equal to the page number, and it issues no strobe or write enable. After a refill written in cycle k, cycle k+1 is a new map phase, so on a hit the strobes start in cycle k+2.
- R11: Refills fill the entries in round-robin order. The 17th refill after reset overwrites the entry filled by the 1st refill, and it leaves the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | Data-port request valid |
| d_ready | output | 1 | Data-port request accepted when high with d_valid |
| d_write | input | 1 | 1 = write, 0 = read |
| d_vaddr | input | 24 | Data-port virtual word address |
| d_len | input | 4 | Data-port word count minus one |
| d_wdata | input | 40 | Write data for the current strobe |
| f_valid | input | 1 | Fetch-port read request valid |
| f_ready | output | 1 | Fetch-port request accepted when high with f_valid |
| f_vaddr | input | 24 | Fetch-port virtual word address |
| f_len | input | 4 | Fetch-port word count minus one |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 40 | Read word |
| rd_fetch | output | 1 | Read word belongs to a fetch access |
| done | output | 1 | Write-back phase of the current access |
| miss | output | 1 | Access waiting on a translation refill |
| miss_vpn | output | 14 | Page number that missed |
| rf_en | input | 1 | Translation refill write |
| rf_vpn | input | 14 | Refill virtual page number |
| rf_ppn | input | 10 | Refill physical page number |
| mem_ras | output | 1 | Row strobe |
| mem_cas | output | 1 | Column strobe, one per word |
| mem_we | output | 1 | Write enable during strobe |
| mem_row | output | 10 | Row address |
| mem_col | output | 10 | Column address |
| mem_wdata | output | 40 | Data to memory |
| mem_rdata | input | 40 | Data from memory during a strobe |

## Verification
Two pairs of functions can coincide. In the first, a fetch request and a data request become valid in the same idle cycle. The bench raises both on one falling edge, then checks that only the data port sees ready. It also checks that the fetch is taken just after the data access's dead cycle, with its words tagged as fetch. In the second, a refill write lands while an access is waiting on a miss. The bench drives the refill during the miss phase and judges the outcome from the strobe timing and the row address that follow. A later miss shows that round-robin replacement evicted the oldest translation and kept the others.

// File: rtl/bms_pkg.sv
package bms_pkg;
    localparam int WORD_W_DEF = 40;
    localparam int VA_W_DEF   = 24;
    localparam int OFF_W_DEF  = 10;
    localparam int PPN_W_DEF  = 10;
    localparam int LEN_W_DEF  = 4;
    localparam int TLB_N_DEF  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAP,
        ST_MISS,
        ST_XFER,
        ST_WB,
        ST_DEAD
    } seq_st_e;
endpackage

// File: rtl/bms_tlb.sv
module bms_tlb #(
    parameter int VPN_W   = 14,
    parameter int PPN_W   = 10,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             rf_en,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]              ptr;
    } tlb_t;

    tlb_t s_d, s_q;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = s_q.vld[i] && (s_q.vpn[i] == lk_vpn);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) lk_ppn = s_q.ppn[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (rf_en) begin
            s_d.vld[s_q.ptr] = 1'b1;
            s_d.vpn[s_q.ptr] = rf_vpn;
            s_d.ppn[s_q.ptr] = rf_ppn;
            if (s_q.ptr == IDX_W'(ENTRIES - 1)) s_d.ptr = '0;
            else                                s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bms_arb.sv
module bms_arb #(
    parameter int VA_W  = 24,
    parameter int LEN_W = 4
) (
    input  logic             idle,
    input  logic             d_valid,
    input  logic             d_write,
    input  logic [VA_W-1:0]  d_vaddr,
    input  logic [LEN_W-1:0] d_len,
    input  logic             f_valid,
    input  logic [VA_W-1:0]  f_vaddr,
    input  logic [LEN_W-1:0] f_len,
    output logic             d_ready,
    output logic             f_ready,
    output logic             take,
    output logic             sel_write,
    output logic             sel_fetch,
    output logic [VA_W-1:0]  sel_vaddr,
    output logic [LEN_W-1:0] sel_len
);
    always_comb begin
        d_ready   = idle;
        f_ready   = idle && !d_valid;
        take      = (d_ready && d_valid) || (f_ready && f_valid);
        sel_fetch = !d_valid;
        sel_write = d_valid && d_write;
        sel_vaddr = d_valid ? d_vaddr : f_vaddr;
        sel_len   = d_valid ? d_len   : f_len;
    end
endmodule

// File: rtl/bms_seq.sv
module bms_seq
    import bms_pkg::*;
#(
    parameter int VA_W   = 24,
    parameter int OFF_W  = 10,
    parameter int PPN_W  = 10,
    parameter int LEN_W  = 4,
    parameter int WORD_W = 40,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int COL_W = PA_W / 2,
    localparam int ROW_W = PA_W - COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              idle,
    input  logic              take,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [LEN_W-1:0]  req_len,
    output logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_hit,
    input  logic [PPN_W-1:0]  lk_ppn,
    input  logic              rf_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_fetch,
    output logic              done,
    output logic              miss,
    output logic [VPN_W-1:0]  miss_vpn,
    output logic              mem_ras,
    output logic              mem_cas,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    input  logic [WORD_W-1:0] mem_rdata
);
    typedef struct packed {
        seq_st_e           st;
        logic              wr;
        logic              fe;
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [PPN_W-1:0]  ppn;
        logic [LEN_W-1:0]  left;
        logic              rv;
        logic [WORD_W-1:0] rd;
        logic              rf;
    } seq_t;

    seq_t s_d, s_q;
    logic [PA_W-1:0] pa;

    always_comb begin
        s_d    = s_q;
        s_d.rv = (s_q.st == ST_XFER) && !s_q.wr;
        s_d.rd = mem_rdata;
        s_d.rf = s_q.fe;
        unique case (s_q.st)
            ST_IDLE: begin
                if (take) begin
                    s_d.st   = ST_MAP;
                    s_d.wr   = req_write;
                    s_d.fe   = req_fetch;
                    s_d.vpn  = req_vaddr[VA_W-1:OFF_W];
                    s_d.off  = req_vaddr[OFF_W-1:0];
                    s_d.left = req_len;
                end
            end
            ST_MAP: begin
                if (lk_hit) begin
                    s_d.st  = ST_XFER;
                    s_d.ppn = lk_ppn;
                end else begin
                    s_d.st = ST_MISS;
                end
            end
            ST_MISS: begin
                if (rf_en) s_d.st = ST_MAP;
            end
            ST_XFER: begin
                s_d.off = s_q.off + 1'b1;
                if (s_q.left == '0) s_d.st = ST_WB;
                else                s_d.left = s_q.left - 1'b1;
            end
            ST_WB:   s_d.st = ST_DEAD;
            ST_DEAD: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pa       = {s_q.ppn, s_q.off};
    assign idle     = (s_q.st == ST_IDLE);
    assign lk_vpn   = s_q.vpn;
    assign rd_valid = s_q.rv;
    assign rd_data  = s_q.rd;
    assign rd_fetch = s_q.rf;
    assign done     = (s_q.st == ST_WB);
    assign miss     = (s_q.st == ST_MISS);
    assign miss_vpn = s_q.vpn;
    assign mem_ras  = (s_q.st == ST_XFER);
    assign mem_cas  = (s_q.st == ST_XFER);
    assign mem_we   = (s_q.st == ST_XFER) && s_q.wr;
    assign mem_row  = pa[PA_W-1:COL_W];
    assign mem_col  = pa[COL_W-1:0];
endmodule

// File: rtl/burst_mem_seq.sv
module burst_mem_seq
    import bms_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int VA_W   = VA_W_DEF,
    parameter int OFF_W  = OFF_W_DEF,
    parameter int PPN_W  = PPN_W_DEF,
    parameter int LEN_W  = LEN_W_DEF,
    parameter int TLB_N  = TLB_N_DEF,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int COL_W = PA_W / 2,
    localparam int ROW_W = PA_W - COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    output logic              d_ready,
    input  logic              d_write,
    input  logic [VA_W-1:0]   d_vaddr,
    input  logic [LEN_W-1:0]  d_len,
    input  logic [WORD_W-1:0] d_wdata,
    input  logic              f_valid,
    output logic              f_ready,
    input  logic [VA_W-1:0]   f_vaddr,
    input  logic [LEN_W-1:0]  f_len,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_fetch,
    output logic              done,
    output logic              miss,
    output logic [VPN_W-1:0]  miss_vpn,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    output logic              mem_ras,
    output logic              mem_cas,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic             idle, take, sel_write, sel_fetch, lk_hit;
    logic [VA_W-1:0]  sel_vaddr;
    logic [LEN_W-1:0] sel_len;
    logic [VPN_W-1:0] lk_vpn;
    logic [PPN_W-1:0] lk_ppn;

    bms_arb #(.VA_W(VA_W), .LEN_W(LEN_W)) i_arb (
        .idle(idle), .d_valid(d_valid), .d_write(d_write), .d_vaddr(d_vaddr),
        .d_len(d_len), .f_valid(f_valid), .f_vaddr(f_vaddr), .f_len(f_len),
        .d_ready(d_ready), .f_ready(f_ready), .take(take), .sel_write(sel_write),
        .sel_fetch(sel_fetch), .sel_vaddr(sel_vaddr), .sel_len(sel_len)
    );

    bms_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_N)) i_tlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn)
    );

    bms_seq #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .LEN_W(LEN_W),
              .WORD_W(WORD_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .idle(idle), .take(take), .req_write(sel_write),
        .req_fetch(sel_fetch), .req_vaddr(sel_vaddr), .req_len(sel_len),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rf_en(rf_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fetch(rd_fetch), .done(done),
        .miss(miss), .miss_vpn(miss_vpn), .mem_ras(mem_ras), .mem_cas(mem_cas),
        .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_rdata(mem_rdata)
    );

    assign mem_wdata = d_wdata;
endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             d_valid,
    input logic             d_ready,
    input logic             f_ready,
    input logic             rd_valid,
    input logic             done,
    input logic             miss,
    input logic             mem_cas,
    input logic             mem_we,
    input logic [ROW_W-1:0] mem_row,
    input logic [COL_W-1:0] mem_col
);
    p_fetch_yields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        f_ready |-> !d_valid);

    p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas && $past(mem_cas)) |-> $stable(mem_row));

    p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas && $past(mem_cas)) |-> (mem_col == $past(mem_col) + COL_W'(1)));

    p_miss_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!mem_cas && !mem_we));

    p_dead_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!d_ready && !f_ready));

    p_rd_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(mem_cas) && !$past(mem_we)));

    p_done_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_cas));
endmodule

bind burst_mem_seq bms_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_ready(d_ready),
    .f_ready(f_ready), .rd_valid(rd_valid), .done(done), .miss(miss),
    .mem_cas(mem_cas), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col)
);

// File: tb/test_burst_mem_seq.sv
`timescale 1ns/1ps
module test_burst_mem_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        d_valid, d_ready, d_write;
    logic [23:0] d_vaddr;
    logic [3:0]  d_len;
    logic [39:0] d_wdata;
    logic        f_valid, f_ready;
    logic [23:0] f_vaddr;
    logic [3:0]  f_len;
    logic        rd_valid, rd_fetch, done, miss;
    logic [39:0] rd_data;
    logic [13:0] miss_vpn;
    logic        rf_en;
    logic [13:0] rf_vpn;
    logic [9:0]  rf_ppn;
    logic        mem_ras, mem_cas, mem_we;
    logic [9:0]  mem_row, mem_col;
    logic [39:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [39:0] mword(input logic [9:0] row, input logic [9:0] col);
        return {row, col, ~row, ~col};
    endfunction

    assign mem_rdata = mword(mem_row, mem_col);

    burst_mem_seq i_burst_mem_seq (
        .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_ready(d_ready),
        .d_write(d_write), .d_vaddr(d_vaddr), .d_len(d_len), .d_wdata(d_wdata),
        .f_valid(f_valid), .f_ready(f_ready), .f_vaddr(f_vaddr), .f_len(f_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fetch(rd_fetch), .done(done),
        .miss(miss), .miss_vpn(miss_vpn), .rf_en(rf_en), .rf_vpn(rf_vpn),
        .rf_ppn(rf_ppn), .mem_ras(mem_ras), .mem_cas(mem_cas), .mem_we(mem_we),
        .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk_eq(input string rq, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic refill(input logic [13:0] vpn, input logic [9:0] ppn);
        rf_en = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
        @(negedge clk);
        rf_en = 1'b0;
    endtask

    // Entered and left on a falling edge. refill_at > 0 expects a miss and refills in that cycle.
    task automatic do_access(input bit wr, input bit fe, input logic [23:0] va,
                             input logic [3:0] len, input logic [9:0] ppn,
                             input int refill_at, input string mtag);
        int n, base;
        string st;
        logic [9:0]  col_e;
        logic [39:0] wd;
        bit exp_rv, exp_m;
        n    = int'(len) + 1;
        base = (refill_at > 0) ? refill_at + 1 : 1;
        st   = (n == 1) ? "R2" : "R3";
        wd   = {16'hC0DE, va};
        if (fe) begin
            f_valid = 1'b1; f_vaddr = va; f_len = len;
        end else begin
            d_valid = 1'b1; d_write = wr; d_vaddr = va; d_len = len; d_wdata = wd;
        end
        #1;
        if (fe) chk_eq("R8", "fetch ready while idle", f_ready, 1);
        else begin
            chk_eq("R7", "data ready while idle", d_ready, 1);
            if (f_valid) chk_eq("R8", "fetch held off by data", f_ready, 0);
        end
        @(posedge clk);
        @(negedge clk);
        if (fe) f_valid = 1'b0; else d_valid = 1'b0;
        for (int c = 1; c <= base + n + 3; c++) begin
            chk_eq((refill_at > 0) ? mtag : st, "column strobe", mem_cas,
                   (c >= base + 1 && c <= base + n));
            if (mem_cas) begin
                col_e = va[9:0] + 10'(c - base - 1);
                chk_eq("R4", "column address", mem_col, col_e);
                chk_eq("R9", "translated row", mem_row, ppn);
                chk_eq("R4", "row strobe", mem_ras, 1);
                chk_eq("R6", "write enable", mem_we, wr);
                if (wr) chk_eq("R6", "write data", mem_wdata, wd);
            end
            exp_rv = !wr && c >= base + 2 && c <= base + n + 1;
            chk_eq(wr ? "R6" : "R5", "read valid", rd_valid, exp_rv);
            if (exp_rv) begin
                col_e = va[9:0] + 10'(c - base - 2);
                chk_eq("R5", "read data", rd_data, mword(ppn, col_e));
                chk_eq("R5", "read source tag", rd_fetch, fe);
            end
            chk_eq(st, "done", done, (c == base + n + 1));
            exp_m = (refill_at > 0) && c >= 2 && c <= refill_at;
            chk_eq(mtag, "miss flag", miss, exp_m);
            if (exp_m) chk_eq(mtag, "miss page", miss_vpn, va[23:10]);
            if (c == base + n + 2) begin
                chk_eq("R7", "dead cycle data ready", d_ready, 0);
                chk_eq("R7", "dead cycle fetch ready", f_ready, 0);
            end
            if (c == base + n + 3) chk_eq("R7", "ready after dead cycle", d_ready, 1);
            if (refill_at > 0 && c == refill_at) begin
                rf_en = 1'b1; rf_vpn = va[23:10]; rf_ppn = ppn;
            end else begin
                rf_en = 1'b0;
            end
            if (c < base + n + 3) @(negedge clk);
        end
    endtask

    // {write, fetch, vaddr[23:0], len[3:0], expected ppn[9:0]}
    localparam int NVEC = 7;
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 14'd1, 10'h005, 4'd0,  10'h123},
        {1'b1, 1'b0, 14'd2, 10'h100, 4'd0,  10'h0AB},
        {1'b0, 1'b0, 14'd3, 10'h010, 4'd7,  10'h3FF},
        {1'b1, 1'b0, 14'd1, 10'h200, 4'd3,  10'h123},
        {1'b0, 1'b0, 14'd2, 10'h3FD, 4'd5,  10'h0AB},
        {1'b0, 1'b1, 14'd3, 10'h3FF, 4'd15, 10'h3FF},
        {1'b1, 1'b0, 14'd1, 10'h000, 4'd15, 10'h123}
    };

    initial begin
        rst_n = 1'b0; d_valid = 0; d_write = 0; d_vaddr = '0; d_len = '0; d_wdata = '0;
        f_valid = 0; f_vaddr = '0; f_len = '0; rf_en = 0; rf_vpn = '0; rf_ppn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "reset data ready", d_ready, 1);
        chk_eq("R1", "reset fetch ready", f_ready, 1);
        chk_eq("R1", "reset strobe", mem_cas, 0);
        chk_eq("R1", "reset write enable", mem_we, 0);
        chk_eq("R1", "reset read valid", rd_valid, 0);
        chk_eq("R1", "reset done", done, 0);
        chk_eq("R1", "reset miss", miss, 0);

        refill(14'd1, 10'h123);
        refill(14'd2, 10'h0AB);
        refill(14'd3, 10'h3FF);

        for (int i = 0; i < NVEC; i++)
            do_access(VEC[i][39], VEC[i][38], VEC[i][37:14], VEC[i][13:10],
                      VEC[i][9:0], 0, "R10");

        // R8: fetch and data raised together
        f_valid = 1'b1; f_vaddr = {14'd3, 10'h040}; f_len = 4'd1;
        do_access(1'b0, 1'b0, {14'd1, 10'h008}, 4'd2, 10'h123, 0, "R10");
        do_access(1'b0, 1'b1, {14'd3, 10'h040}, 4'd1, 10'h3FF, 0, "R10");

        // R10: miss, refill while waiting, then a write burst
        do_access(1'b1, 1'b0, {14'd9, 10'h020}, 4'd2, 10'h155, 4, "R10");

        // R11: fill the rest, then one more evicts the first refill
        for (int v = 20; v < 32; v++) refill(14'(v), 10'(v));
        refill(14'd40, 10'h2AA);
        do_access(1'b0, 1'b0, {14'd1, 10'h0F0}, 4'd1, 10'h123, 3, "R11");
        do_access(1'b0, 1'b0, {14'd3, 10'h001}, 4'd0, 10'h3FF, 0, "R11");
        do_access(1'b0, 1'b0, {14'd40, 10'h000}, 4'd0, 10'h2AA, 0, "R11");
        do_access(1'b0, 1'b0, {14'd31, 10'h3FF}, 4'd1, 10'd31, 0, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule